// File: doc/BRIEF.md
# Multi-Stream Synchronized Start Gate

This block decides, one link frame at a time, which DMA streams of a frame-based serial audio link may move data. Each stream has a software hold bit, a RUN input from its DMA engine and a registered transfer-enable output. On each frame-start pulse every stream takes a new state from its RUN input and its hold bit. Its enable is high only when RUN is set and hold is clear. Several streams can therefore be started or stopped on exactly the same frame. Software sets the hold bits and then the RUN bits. It waits for the FIFOs to fill and then clears all hold bits in one write. To stop, it sets the hold bits and then drops RUN.

The block also holds a free-running wall clock counter. The counter advances once per link bit-clock tick while the link clock enable is high, and it wraps to zero. Software reads it to line up timing across controllers. A small word-indexed register port gives access to the wall clock (index 0, read-only) and the hold register (index 1, read/write). Other indices read as zero.

Each stream runs a three-state machine: IDLE (RUN low), HELD (RUN high, hold set) and XFER (RUN high, hold clear). Transitions happen only on a frame-start cycle. The next state is XFER when RUN=1 and hold=0, HELD when RUN=1 and hold=1, and IDLE when RUN=0. Between frame pulses every state stays where it is.

Top module: `stream_start_gate`

## Requirements
- R1: After reset the hold register reads 0, the wall clock reads 0 and every transfer enable is 0.
- R2: The hold register at index 1 stores write bits [N_STREAMS-1:0] one cycle after the write. Bits above the stream count always read 0.
- R3: Hold bit i and RUN bit i govern transfer enable bit i. Bits 0..3 are input streams 1..4 and bit 4 is output stream 1.
- R4: A stream whose hold bit is 1 at a frame start has enable 0 after that frame start, even with RUN high.
- R5: Transfer enables change only on the clock edge of a frame-start cycle. A hold or RUN change between frame starts has no effect on them until the next pulse.
- R6: When one write clears the hold bits of several running streams, all of their enables rise on the same cycle: the edge of the first frame start after the write.
- R7: A hold bit cleared by a write in the same cycle as a frame-start pulse is not released by that pulse. The release takes effect at the following frame start.
- R8: A stream whose hold bit stays 0 has its enable rise at the first frame start after RUN is set.
- R9: Setting the hold bits of several transferring streams drops all of their enables together at the next frame start, whatever their RUN bits are.
- R10: The wall clock at index 0 adds 1 on each cycle where both bit_tick and link_en are 1. It holds otherwise, wraps from all ones to 0, and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word index (1 = hold register) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word index (0 = wall clock, 1 = hold) |
| rd_data | output | DATA_W | Combinational read data |
| link_en | input | 1 | Link clock enable; wall clock counts only while high |
| bit_tick | input | 1 | One-cycle pulse per link bit-clock period |
| frame_start | input | 1 | One-cycle pulse at each link frame boundary |
| run | input | N_STREAMS | Per-stream RUN bits from the DMA engines |
| xfer_en | output | N_STREAMS | Per-stream transfer enable, registered at frame starts |

## Verification
A register write lands on the clock edge of its write cycle, so read-back is correct one cycle after the strobe. Transfer enables change only on the edge of a frame-start cycle, and each check samples them on the falling edge right after that edge, and also before any pulse to show they have not moved. The wall clock is compared with a count of the qualified ticks that the bench keeps itself. A second instance with a 4-bit counter shows the wrap without running through 2^32 ticks. All inputs are driven and all outputs sampled on falling edges, so every result is due exactly one rising edge after its stimulus.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    // Word indices of the register port
    localparam int unsigned IDX_WCLK = 0;
    localparam int unsigned IDX_HOLD = 1;

    // Per-stream gate state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_XFER = 2'd2
    } gate_state_t;

endpackage

// File: rtl/ssg_wallclock.sv
module ssg_wallclock #(
    parameter int unsigned WCLK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              bit_tick,
    output logic [WCLK_W-1:0] count
);

    logic step;

    assign step = link_en & bit_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;   // wraps naturally from all ones
        end
    end

endmodule

// File: rtl/ssg_regs.sv
module ssg_regs
    import ssg_pkg::*;
#(
    parameter int unsigned N_STREAMS = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned WCLK_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [WCLK_W-1:0] wclk,
    output logic [DATA_W-1:0] hold_q
);

    localparam logic [DATA_W-1:0] HOLD_MASK = DATA_W'((64'd1 << N_STREAMS) - 64'd1);
    localparam logic [ADDR_W-1:0] A_WCLK    = ADDR_W'(IDX_WCLK);
    localparam logic [ADDR_W-1:0] A_HOLD    = ADDR_W'(IDX_HOLD);

    logic hold_we;

    assign hold_we = wr_en && (wr_addr == A_HOLD);

    // Reserved bits are masked on the way in, so they always read 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_we) begin
            hold_q <= wr_data & HOLD_MASK;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_WCLK) begin
            rd_data = DATA_W'(wclk);
        end else if (rd_addr == A_HOLD) begin
            rd_data = hold_q;
        end
    end

endmodule

// File: rtl/ssg_stream_fsm.sv
module ssg_stream_fsm
    import ssg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic run,
    input  logic hold,
    output logic xfer_en
);

    gate_state_t state_q;
    gate_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: only a frame-start cycle moves the state
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            unique case ({run, hold})
                2'b10:   state_d = ST_XFER;
                2'b11:   state_d = ST_HELD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_XFER: xfer_en = 1'b1;
            ST_HELD: xfer_en = 1'b0;
            ST_IDLE: xfer_en = 1'b0;
            default: xfer_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/stream_start_gate.sv
module stream_start_gate
    import ssg_pkg::*;
#(
    parameter int unsigned N_STREAMS = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned WCLK_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 link_en,
    input  logic                 bit_tick,
    input  logic                 frame_start,
    input  logic [N_STREAMS-1:0] run,
    output logic [N_STREAMS-1:0] xfer_en
);

    logic [WCLK_W-1:0] wclk_val;
    logic [DATA_W-1:0] hold_word;

    ssg_wallclock #(
        .WCLK_W (WCLK_W)
    ) u_wclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .bit_tick (bit_tick),
        .count    (wclk_val)
    );

    ssg_regs #(
        .N_STREAMS (N_STREAMS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .WCLK_W    (WCLK_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wclk    (wclk_val),
        .hold_q  (hold_word)
    );

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
        ssg_stream_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .run         (run[s]),
            .hold        (hold_word[s]),
            .xfer_en     (xfer_en[s])
        );
    end

endmodule

// File: rtl/ssg_chk.sv
module ssg_chk #(
    parameter int unsigned N_STREAMS = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WCLK_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic [N_STREAMS-1:0] run,
    input logic [DATA_W-1:0]    hold,
    input logic [N_STREAMS-1:0] xfer_en,
    input logic                 link_en,
    input logic                 bit_tick,
    input logic [WCLK_W-1:0]    wclk
);

    localparam logic [DATA_W-1:0] RSV_MASK = ~DATA_W'((64'd1 << N_STREAMS) - 64'd1);

    // R5
    xfer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(xfer_en));

    // R4
    held_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> ((xfer_en & $past(hold[N_STREAMS-1:0])) == '0));

    // R3
    run_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> ((xfer_en & ~$past(run)) == '0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold & RSV_MASK) == '0);

    // R10
    wclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_en && bit_tick) |=> $stable(wclk));

    // R10
    wclk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && bit_tick) |=> (wclk == WCLK_W'($past(wclk) + 1'b1)));

endmodule

bind stream_start_gate ssg_chk #(
    .N_STREAMS (N_STREAMS),
    .DATA_W    (DATA_W),
    .WCLK_W    (WCLK_W)
) u_ssg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .run         (run),
    .hold        (hold_word),
    .xfer_en     (xfer_en),
    .link_en     (link_en),
    .bit_tick    (bit_tick),
    .wclk        (wclk_val)
);

// File: tb/stream_start_gate_bench.sv
module stream_start_gate_bench;

    localparam int unsigned N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] rd_data_n;
    logic        link_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        frame_start = 1'b0;
    logic [N-1:0] run = '0;
    logic [N-1:0] xfer_en;
    logic [N-1:0] xfer_en_n;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_cnt = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    stream_start_gate u_stream_start_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .link_en(link_en), .bit_tick(bit_tick), .frame_start(frame_start),
        .run(run), .xfer_en(xfer_en)
    );

    // Narrow wall clock instance used only to observe the wrap
    stream_start_gate #(.WCLK_W(4)) u_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_n),
        .link_en(link_en), .bit_tick(bit_tick), .frame_start(frame_start),
        .run(run), .xfer_en(xfer_en_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = idx; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] idx, output logic [31:0] val);
        rd_addr = idx;
        #0.5;
        val = rd_data;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        reg_read(2'd1, v); check("R1 hold", v, 32'h0);
        reg_read(2'd0, v); check("R1 wclk", v, 32'h0);
        check("R1 xfer_en", 32'(xfer_en), 32'h0);
    endtask

    task automatic test_hold_rw();
        logic [31:0] v;
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, v); check("R2 reserved zero", v, 32'h1F);
        reg_write(2'd1, 32'h0000_000A);
        reg_read(2'd1, v); check("R2 readback", v, 32'h0A);
        reg_write(2'd1, 32'h0);
        reg_read(2'd3, v); check("R2 unused index", v, 32'h0);
    endtask

    task automatic test_unheld();
        @(negedge clk); run = 5'b00001;
        @(negedge clk); check("R5 no change without frame", 32'(xfer_en), 32'h0);
        frame_pulse();
        check("R8 unheld start", 32'(xfer_en), 32'h01);
        @(negedge clk); run = 5'b0;
        frame_pulse();
        check("R8 stop on run low", 32'(xfer_en), 32'h0);
    endtask

    task automatic test_sync_start();
        reg_write(2'd1, 32'h1F);
        @(negedge clk); run = 5'b11111;
        frame_pulse();
        check("R4 held with run", 32'(xfer_en), 32'h0);
        reg_write(2'd1, 32'h0);
        @(negedge clk); check("R5 release waits for frame", 32'(xfer_en), 32'h0);
        frame_pulse();
        check("R6 all released together", 32'(xfer_en), 32'h1F);
    endtask

    task automatic test_sync_stop();
        reg_write(2'd1, 32'h1F);
        check("R5 stop waits for frame", 32'(xfer_en), 32'h1F);
        frame_pulse();
        check("R9 all stop together", 32'(xfer_en), 32'h0);
        @(negedge clk); run = 5'b0;
        reg_write(2'd1, 32'h0);
        frame_pulse();
        check("R9 stay stopped", 32'(xfer_en), 32'h0);
    endtask

    task automatic test_same_cycle();
        reg_write(2'd1, 32'h1F);
        @(negedge clk); run = 5'b11111;
        frame_pulse();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0; frame_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_start = 1'b0;
        check("R7 not released same cycle", 32'(xfer_en), 32'h0);
        frame_pulse();
        check("R7 released next frame", 32'(xfer_en), 32'h1F);
    endtask

    task automatic test_mapping();
        reg_write(2'd1, 32'h10);
        frame_pulse();
        check("R3 output stream held", 32'(xfer_en), 32'h0F);
        reg_write(2'd1, 32'h05);
        frame_pulse();
        check("R3 input streams 1,3 held", 32'(xfer_en), 32'h1A);
        @(negedge clk); run = 5'b0;
        reg_write(2'd1, 32'h0);
        frame_pulse();
    endtask

    task automatic test_wclk();
        logic [31:0] v;
        @(negedge clk); link_en = 1'b0; bit_tick = 1'b1;
        repeat (5) @(negedge clk);
        reg_read(2'd0, v); check("R10 gated by link_en", v, 32'(tick_cnt));
        link_en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); tick_cnt++;
        end
        bit_tick = 1'b0;
        reg_read(2'd0, v); check("R10 counts ticks", v, 32'(tick_cnt));
        repeat (3) @(negedge clk);
        reg_read(2'd0, v); check("R10 holds without tick", v, 32'(tick_cnt));
        reg_write(2'd0, 32'hDEAD_BEEF);
        reg_read(2'd0, v); check("R10 write ignored", v, 32'(tick_cnt));
        check("R10 narrow wrap", rd_data_n, 32'(tick_cnt % 16));
        link_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_wclk();
        test_hold_rw();
        test_unheld();
        test_sync_start();
        test_sync_stop();
        test_same_cycle();
        test_mapping();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule